// File: doc/BRIEF.md
# Tag cache lookup engine

This block keeps a small direct-mapped cache of one-bit capability tags next to a memory proxy. The proxy copies every data request it forwards into this engine as well. Each covered address granule of 32 bytes owns a single tag bit. The authoritative copy of all tag bits lives in a table placed in the highest part of the memory address space. The engine fetches table lines into its local store on demand. It updates the cached bits on writes and writes a modified line back to the table only when that line is evicted.

For every read the engine hands back one tag response. A covered response holds a small vector with one entry per flit of the read burst. The consumer steps through this vector frame by frame and releases it on the last flit. An address at or above the table base is not covered by tag storage. A read there gets an "uncovered" response, which the consumer treats as all tags clear. Table traffic leaves the engine as ordinary memory requests with the fixed requester ID 12. Memory responses can therefore be routed back to the engine and kept off the data path. The engine handles one request at a time, so its responses come back in request order.

Top module: `tag_lookup_engine`

## Requirements
- R1: After reset every cached line is invalid, `req_ready` is 1, and `rsp_valid`, `mreq_valid` and `mrsp_ready` are 0. The first covered access to any line therefore causes a table fetch.
- R2: A read whose address is greater than or equal to `TABLE_BASE` produces one response with `rsp_covered` = 0 and `rsp_tags` = 0, and it issues no memory request.
- R3: A covered read that hits produces one response with `rsp_covered` = 1. Let p be the granule position of the request address inside its tag line, address bits [GRAN_LOG2 +: log2(LINE_TAGS)]. Then `rsp_tags[f]` holds the tag of position (p + f) mod `LINE_TAGS` of the same line, for every f from 0 to FRAMES-1. The response appears on the second rising edge after the request is accepted.
- R4: A covered write sets the tag at position (p + f) mod `LINE_TAGS` to `req_wtags[f]` for f = 0 .. `req_len`. It returns no response. A write hit issues no memory request, and the changed bits are visible to later reads.
- R5: A miss issues a read with `mreq_write` = 0 and `mreq_id` = 12. Its address is `TABLE_BASE` + (addr >> GRAN_LOG2 >> log2(LINE_TAGS)) * (LINE_TAGS/8). In the returned `mrsp_data`, bit k is the tag of granule position k of that line.
- R6: When the slot a miss maps to holds a modified line, the engine first issues a write with `mreq_write` = 1 and `mreq_id` = 12. The write goes to that victim's table address and carries its full tag line. The fill read follows directly after the write is accepted. A clean victim is replaced without any write.
- R7: While a fill is outstanding, a memory response whose `mrsp_id` is not 12 is ignored and the engine keeps waiting.
- R8: Only one request is in flight. `req_ready` stays 0 from acceptance until the engine is idle and any response has been taken, and responses come out in request order.
- R9: A tag line that was modified, evicted and fetched again reads back with the values that were written.
- R10: A write whose address is greater than or equal to `TABLE_BASE` has no effect. It produces no response and no memory request.
- R11: A memory request holds `mreq_valid`, `mreq_write` and `mreq_addr` stable until `mreq_ready` is seen.
- R12: A response holds `rsp_valid`, `rsp_covered` and `rsp_tags` stable until `rsp_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request copy from the proxy is offered |
| req_ready | output | 1 | Engine can accept a request this cycle |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_addr | input | ADDR_W | Byte address of the first flit |
| req_len | input | log2(FRAMES) | Flits in the burst minus one |
| req_wtags | input | FRAMES | Per-flit tag values of a write |
| rsp_valid | output | 1 | Tag response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_covered | output | 1 | 1 = tag vector valid, 0 = address not covered |
| rsp_tags | output | FRAMES | Tag per frame of the read burst |
| mreq_valid | output | 1 | Table request to memory offered |
| mreq_ready | input | 1 | Memory accepts the table request |
| mreq_write | output | 1 | 1 = writeback, 0 = fill read |
| mreq_addr | output | ADDR_W | Byte address of the table line |
| mreq_id | output | 4 | Requester ID, always 12 |
| mreq_wdata | output | LINE_TAGS | Tag line carried by a writeback |
| mrsp_valid | input | 1 | Memory response present |
| mrsp_ready | output | 1 | Engine is waiting for fill data |
| mrsp_id | input | 4 | Requester ID of the memory response |
| mrsp_data | input | LINE_TAGS | Returned tag-table line |

## Verification
The bench builds the engine with ADDR_W = 24, NUM_LINES = 8, LINE_TAGS = 256, FRAMES = 4 and TABLE_BASE = 0xF00000. With only eight slots, addresses 64 KB apart land in the same slot. This puts dirty evictions, clean replacements and the write-back-then-refetch path within a handful of requests. The 24-bit space keeps the uncovered region one short address away. Bursts start at arbitrary granules, so the frame wrap at positions 255 to 0 of a line is reached. A stray response with a foreign ID is injected into every fill wait.

// File: rtl/tle_pkg.sv
package tle_pkg;

    localparam int ID_W = 4;
    // requester ID stamped on every tag-table access
    localparam logic [ID_W-1:0] TAG_MASTER_ID = 4'd12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB_REQ,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } eng_state_e;

    // bytes of table storage used by one tag line
    function automatic int line_bytes(input int line_tags);
        return line_tags / 8;
    endfunction

endpackage

// File: rtl/tle_addr_map.sv
module tle_addr_map #(
    parameter int          ADDR_W     = 28,
    parameter int          GRAN_LOG2  = 5,
    parameter int          LPOS_W     = 8,
    parameter int          IDX_W      = 7,
    parameter int          KEY_W      = 8,
    parameter int          LB_LOG2    = 5,
    parameter logic [63:0] TABLE_BASE = 64'h0FF0_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [KEY_W-1:0]  victim_key,
    output logic              covered,
    output logic [IDX_W-1:0]  idx,
    output logic [KEY_W-1:0]  key,
    output logic [LPOS_W-1:0] lpos,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int LNUM_W = KEY_W + IDX_W;
    localparam logic [ADDR_W-1:0] BASE_A = TABLE_BASE[ADDR_W-1:0];

    logic [LNUM_W-1:0] lnum;
    logic [LNUM_W-1:0] victim_lnum;

    assign lnum        = addr[ADDR_W-1 -: LNUM_W];
    assign covered     = (addr < BASE_A);
    assign idx         = lnum[IDX_W-1:0];
    assign key         = lnum[LNUM_W-1:IDX_W];
    assign lpos        = addr[GRAN_LOG2 +: LPOS_W];
    assign victim_lnum = {victim_key, idx};

    // table line address: base plus line number times line size in bytes
    assign fill_addr = BASE_A + (ADDR_W'(lnum) << LB_LOG2);
    assign wb_addr   = BASE_A + (ADDR_W'(victim_lnum) << LB_LOG2);

endmodule

// File: rtl/tle_store.sv
module tle_store #(
    parameter int NUM_LINES = 128,
    parameter int LINE_TAGS = 256,
    parameter int IDX_W     = 7,
    parameter int KEY_W     = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     idx,
    output logic [LINE_TAGS-1:0] rd_line,
    output logic [KEY_W-1:0]     rd_key,
    output logic                 rd_valid,
    output logic                 rd_dirty,
    input  logic                 fill_en,
    input  logic [KEY_W-1:0]     fill_key,
    input  logic [LINE_TAGS-1:0] fill_line,
    input  logic                 upd_en,
    input  logic [LINE_TAGS-1:0] upd_line,
    input  logic                 clean_en
);
    logic [LINE_TAGS-1:0] line_mem [NUM_LINES];
    logic [KEY_W-1:0]     key_mem  [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;

    assign rd_line  = line_mem[idx];
    assign rd_key   = key_mem[idx];
    assign rd_valid = valid_q[idx];
    assign rd_dirty = dirty_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_en) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (upd_en) begin
            dirty_q[idx] <= 1'b1;
        end else if (clean_en) begin
            dirty_q[idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            line_mem[idx] <= fill_line;
            key_mem[idx]  <= fill_key;
        end else if (upd_en) begin
            line_mem[idx] <= upd_line;
        end
    end

endmodule

// File: rtl/tle_frame_unit.sv
module tle_frame_unit #(
    parameter int LINE_TAGS = 256,
    parameter int LPOS_W    = 8,
    parameter int FRAMES    = 4,
    parameter int LEN_W     = 2
) (
    input  logic [LINE_TAGS-1:0] line,
    input  logic [LPOS_W-1:0]    lpos,
    input  logic [LEN_W-1:0]     len,
    input  logic [FRAMES-1:0]    wtags,
    output logic [FRAMES-1:0]    rd_tags,
    output logic [LINE_TAGS-1:0] upd_line
);
    logic [LPOS_W-1:0] pos [FRAMES];

    // frame positions wrap inside the tag line
    for (genvar f = 0; f < FRAMES; f++) begin : g_frame
        assign pos[f]     = lpos + LPOS_W'(f);
        assign rd_tags[f] = line[pos[f]];
    end

    always_comb begin
        upd_line = line;
        for (int f = 0; f < FRAMES; f++) begin
            if (f <= int'(len)) upd_line[pos[f]] = wtags[f];
        end
    end

endmodule

// File: rtl/tag_lookup_engine.sv
module tag_lookup_engine
    import tle_pkg::*;
#(
    parameter int          ADDR_W        = 28,
    parameter int          NUM_LINES     = 128,
    parameter int          LINE_TAGS     = 256,
    parameter int          GRANULE_BYTES = 32,
    parameter int          FRAMES        = 4,
    parameter logic [63:0] TABLE_BASE    = 64'h0FF0_0000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    output logic                       req_ready,
    input  logic                       req_write,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [$clog2(FRAMES)-1:0]  req_len,
    input  logic [FRAMES-1:0]          req_wtags,
    output logic                       rsp_valid,
    input  logic                       rsp_ready,
    output logic                       rsp_covered,
    output logic [FRAMES-1:0]          rsp_tags,
    output logic                       mreq_valid,
    input  logic                       mreq_ready,
    output logic                       mreq_write,
    output logic [ADDR_W-1:0]          mreq_addr,
    output logic [ID_W-1:0]            mreq_id,
    output logic [LINE_TAGS-1:0]       mreq_wdata,
    input  logic                       mrsp_valid,
    output logic                       mrsp_ready,
    input  logic [ID_W-1:0]            mrsp_id,
    input  logic [LINE_TAGS-1:0]       mrsp_data
);
    localparam int GRAN_LOG2 = $clog2(GRANULE_BYTES);
    localparam int LPOS_W    = $clog2(LINE_TAGS);
    localparam int IDX_W     = $clog2(NUM_LINES);
    localparam int LNUM_W    = ADDR_W - GRAN_LOG2 - LPOS_W;
    localparam int KEY_W     = LNUM_W - IDX_W;
    localparam int LEN_W     = $clog2(FRAMES);
    localparam int LB_LOG2   = $clog2(line_bytes(LINE_TAGS));

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic [FRAMES-1:0] wtags;
    } cur_req_t;

    eng_state_e state_q;
    cur_req_t   cur_q;

    logic                 covered;
    logic [IDX_W-1:0]     idx;
    logic [KEY_W-1:0]     key;
    logic [LPOS_W-1:0]    lpos;
    logic [ADDR_W-1:0]    fill_addr;
    logic [ADDR_W-1:0]    wb_addr;
    logic [LINE_TAGS-1:0] st_line;
    logic [KEY_W-1:0]     st_key;
    logic                 st_valid;
    logic                 st_dirty;
    logic [FRAMES-1:0]    rd_tags;
    logic [LINE_TAGS-1:0] upd_line;
    logic                 hit;
    logic                 fill_en;
    logic                 upd_en;
    logic                 clean_en;
    logic                 own_rsp;

    tle_addr_map #(
        .ADDR_W    (ADDR_W),
        .GRAN_LOG2 (GRAN_LOG2),
        .LPOS_W    (LPOS_W),
        .IDX_W     (IDX_W),
        .KEY_W     (KEY_W),
        .LB_LOG2   (LB_LOG2),
        .TABLE_BASE(TABLE_BASE)
    ) u_map (
        .addr      (cur_q.addr),
        .victim_key(st_key),
        .covered   (covered),
        .idx       (idx),
        .key       (key),
        .lpos      (lpos),
        .fill_addr (fill_addr),
        .wb_addr   (wb_addr)
    );

    tle_store #(
        .NUM_LINES(NUM_LINES),
        .LINE_TAGS(LINE_TAGS),
        .IDX_W    (IDX_W),
        .KEY_W    (KEY_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .idx      (idx),
        .rd_line  (st_line),
        .rd_key   (st_key),
        .rd_valid (st_valid),
        .rd_dirty (st_dirty),
        .fill_en  (fill_en),
        .fill_key (key),
        .fill_line(mrsp_data),
        .upd_en   (upd_en),
        .upd_line (upd_line),
        .clean_en (clean_en)
    );

    tle_frame_unit #(
        .LINE_TAGS(LINE_TAGS),
        .LPOS_W   (LPOS_W),
        .FRAMES   (FRAMES),
        .LEN_W    (LEN_W)
    ) u_frames (
        .line    (st_line),
        .lpos    (lpos),
        .len     (cur_q.len),
        .wtags   (cur_q.wtags),
        .rd_tags (rd_tags),
        .upd_line(upd_line)
    );

    assign hit      = st_valid && (st_key == key);
    assign own_rsp  = mrsp_valid && (mrsp_id == TAG_MASTER_ID);
    assign fill_en  = (state_q == ST_FILL_WAIT) && own_rsp;
    assign upd_en   = (state_q == ST_LOOKUP) && covered && hit && cur_q.write;
    assign clean_en = (state_q == ST_WB_REQ) && mreq_ready;

    assign req_ready  = (state_q == ST_IDLE) && !rsp_valid;
    assign mrsp_ready = (state_q == ST_FILL_WAIT);
    assign mreq_valid = (state_q == ST_WB_REQ) || (state_q == ST_FILL_REQ);
    assign mreq_write = (state_q == ST_WB_REQ);
    assign mreq_addr  = (state_q == ST_WB_REQ) ? wb_addr : fill_addr;
    assign mreq_id    = TAG_MASTER_ID;
    assign mreq_wdata = st_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cur_q       <= '0;
            rsp_valid   <= 1'b0;
            rsp_covered <= 1'b0;
            rsp_tags    <= '0;
        end else begin
            if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid && req_ready) begin
                        cur_q.write <= req_write;
                        cur_q.addr  <= req_addr;
                        cur_q.len   <= req_len;
                        cur_q.wtags <= req_wtags;
                        state_q     <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (!covered) begin
                        if (!cur_q.write) begin
                            rsp_valid   <= 1'b1;
                            rsp_covered <= 1'b0;
                            rsp_tags    <= '0;
                        end
                        state_q <= ST_IDLE;
                    end else if (hit) begin
                        if (!cur_q.write) begin
                            rsp_valid   <= 1'b1;
                            rsp_covered <= 1'b1;
                            rsp_tags    <= rd_tags;
                        end
                        state_q <= ST_IDLE;
                    end else if (st_valid && st_dirty) begin
                        state_q <= ST_WB_REQ;
                    end else begin
                        state_q <= ST_FILL_REQ;
                    end
                end
                ST_WB_REQ: begin
                    if (mreq_ready) state_q <= ST_FILL_REQ;
                end
                ST_FILL_REQ: begin
                    if (mreq_ready) state_q <= ST_FILL_WAIT;
                end
                ST_FILL_WAIT: begin
                    if (own_rsp) state_q <= ST_LOOKUP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tle_checker.sv
module tle_checker #(
    parameter int ADDR_W = 28,
    parameter int FRAMES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic              rsp_covered,
    input logic [FRAMES-1:0] rsp_tags,
    input logic              mreq_valid,
    input logic              mreq_ready,
    input logic              mreq_write,
    input logic [ADDR_W-1:0] mreq_addr,
    input logic [3:0]        mreq_id,
    input logic              mrsp_ready
);
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> req_ready && !rsp_valid && !mreq_valid && !mrsp_ready);

    a_r2_uncovered_clear: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_covered |-> rsp_tags == '0);

    a_r5_fixed_id: assert property (@(posedge clk) disable iff (rst)
        mreq_valid |-> mreq_id == 4'd12);

    a_r6_fill_after_wb: assert property (@(posedge clk) disable iff (rst)
        mreq_valid && mreq_write && mreq_ready |=> mreq_valid && !mreq_write);

    a_r8_busy_mem: assert property (@(posedge clk) disable iff (rst)
        (mreq_valid || mrsp_ready) |-> !req_ready);

    a_r8_busy_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    a_r11_mreq_hold: assert property (@(posedge clk) disable iff (rst)
        mreq_valid && !mreq_ready |=> mreq_valid && $stable(mreq_addr) && $stable(mreq_write));

    a_r12_rsp_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_tags) && $stable(rsp_covered));

endmodule

bind tag_lookup_engine tle_checker #(
    .ADDR_W(ADDR_W),
    .FRAMES(FRAMES)
) u_tle_checker (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_covered(rsp_covered),
    .rsp_tags   (rsp_tags),
    .mreq_valid (mreq_valid),
    .mreq_ready (mreq_ready),
    .mreq_write (mreq_write),
    .mreq_addr  (mreq_addr),
    .mreq_id    (mreq_id),
    .mrsp_ready (mrsp_ready)
);

// File: tb/test_tag_lookup_engine.sv
module test_tag_lookup_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 24;
    localparam int NL    = 8;
    localparam int LT    = 256;
    localparam int FR    = 4;
    localparam int BASE  = 24'hF00000;
    localparam int LBYTE = LT / 8;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic           req_write = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [1:0]     req_len = '0;
    logic [FR-1:0]  req_wtags = '0;
    logic           rsp_valid;
    logic           rsp_ready = 1'b1;
    logic           rsp_covered;
    logic [FR-1:0]  rsp_tags;
    logic           mreq_valid;
    logic           mreq_ready = 1'b0;
    logic           mreq_write;
    logic [AW-1:0]  mreq_addr;
    logic [3:0]     mreq_id;
    logic [LT-1:0]  mreq_wdata;
    logic           mrsp_valid = 1'b0;
    logic           mrsp_ready;
    logic [3:0]     mrsp_id = '0;
    logic [LT-1:0]  mrsp_data = '0;

    tag_lookup_engine #(
        .ADDR_W(AW), .NUM_LINES(NL), .LINE_TAGS(LT), .GRANULE_BYTES(32),
        .FRAMES(FR), .TABLE_BASE(64'(BASE))
    ) i_tag_lookup_engine (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wtags(req_wtags),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_covered(rsp_covered),
        .rsp_tags(rsp_tags),
        .mreq_valid(mreq_valid), .mreq_ready(mreq_ready), .mreq_write(mreq_write),
        .mreq_addr(mreq_addr), .mreq_id(mreq_id), .mreq_wdata(mreq_wdata),
        .mrsp_valid(mrsp_valid), .mrsp_ready(mrsp_ready), .mrsp_id(mrsp_id),
        .mrsp_data(mrsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct packed { logic wr; logic [AW-1:0] addr; logic [LT-1:0] data; } mexp_t;
    typedef struct packed { logic cov; logic [FR-1:0] tags; } rexp_t;

    mexp_t       mexp_q[$];
    rexp_t       rexp_q[$];
    string       rtag_q[$];
    bit          ref_tag[int];
    bit [LT-1:0] mem[int];
    int          m_ln[NL];
    bit          m_v[NL];
    bit          m_d[NL];

    int checks = 0, fails = 0;
    int mcount = 0, rcount = 0, wbcount = 0;
    int pend_cnt = 0, pend_ln = 0, rsp_stall = 0, cyc = 0;
    bit mrdy_t = 1'b0, have_last = 1'b0, done = 1'b0;
    logic [FR-1:0] last_tags;
    logic          last_cov;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [LT-1:0] act, input logic [LT-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    function automatic bit pat_bit(input int g);
        return ((g * 5 + g / 7) % 3) == 0;
    endfunction

    function automatic bit get_tag(input int g);
        if (ref_tag.exists(g)) return ref_tag[g];
        return pat_bit(g);
    endfunction

    function automatic logic [LT-1:0] ref_line(input int ln);
        logic [LT-1:0] b;
        for (int k = 0; k < LT; k++) b[k] = get_tag(ln * LT + k);
        return b;
    endfunction

    function automatic logic [LT-1:0] mem_line(input int ln);
        logic [LT-1:0] b;
        if (mem.exists(ln)) return mem[ln];
        for (int k = 0; k < LT; k++) b[k] = pat_bit(ln * LT + k);
        return b;
    endfunction

    // reference model: logical tag state plus direct-mapped occupancy
    task automatic model(input bit wr, input int addr, input int len,
                         input logic [FR-1:0] wt, input string tag);
        int ln, ix, lp;
        rexp_t r;
        if (addr >= BASE) begin
            if (!wr) begin
                r.cov = 1'b0; r.tags = '0;
                rexp_q.push_back(r); rtag_q.push_back(tag);
            end
            return;
        end
        ln = addr >> 13; ix = ln % NL; lp = (addr >> 5) % LT;
        if (!(m_v[ix] && m_ln[ix] == ln)) begin
            if (m_v[ix] && m_d[ix])
                mexp_q.push_back({1'b1, AW'(BASE + m_ln[ix] * LBYTE), ref_line(m_ln[ix])});
            mexp_q.push_back({1'b0, AW'(BASE + ln * LBYTE), {LT{1'b0}}});
            m_v[ix] = 1'b1; m_ln[ix] = ln; m_d[ix] = 1'b0;
        end
        if (wr) begin
            for (int f = 0; f <= len; f++) ref_tag[ln * LT + (lp + f) % LT] = wt[f];
            m_d[ix] = 1'b1;
        end else begin
            r.cov = 1'b1;
            for (int f = 0; f < FR; f++) r.tags[f] = get_tag(ln * LT + (lp + f) % LT);
            rexp_q.push_back(r); rtag_q.push_back(tag);
        end
    endtask

    // called and returns at a falling edge
    task automatic do_req(input bit wr, input int addr, input int len,
                          input logic [FR-1:0] wt, input string tag);
        req_valid = 1'b1; req_write = wr; req_addr = AW'(addr);
        req_len = 2'(len); req_wtags = wt;
        while (!req_ready) @(negedge clk);
        model(wr, addr, len, wt, tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic drain();
        for (int i = 0; i < 400; i++) begin
            if (rexp_q.size() == 0 && mexp_q.size() == 0 && req_ready && !rsp_valid) break;
            @(negedge clk);
        end
    endtask

    // per-cycle comparison against the reference, plus memory and consumer models
    always @(negedge clk) begin
        if (!rst && !done) begin
            mexp_t e;
            rexp_t r;
            string t;
            chk(!((mreq_valid || rsp_valid || mrsp_ready) && req_ready), "R8",
                "ready while busy", {255'b0, req_ready}, '0);
            // memory response pulse
            mrsp_valid = 1'b0;
            if (pend_cnt > 0) begin
                pend_cnt--;
                if (pend_cnt == 2) begin
                    mrsp_valid = 1'b1; mrsp_id = 4'd5; mrsp_data = '1;
                end else if (pend_cnt == 0) begin
                    chk(mrsp_ready, "R5", "fill wait ready", {255'b0, mrsp_ready}, 1);
                    mrsp_valid = 1'b1; mrsp_id = 4'd12; mrsp_data = mem_line(pend_ln);
                end
            end
            // memory request side
            mrdy_t = ~mrdy_t;
            mreq_ready = mrdy_t;
            if (mreq_valid && mreq_ready) begin
                mcount++;
                if (mexp_q.size() == 0) begin
                    chk(1'b0, "R5 R6", "unexpected memory request", {231'b0, mreq_addr}, '0);
                end else begin
                    e = mexp_q.pop_front();
                    chk(mreq_write == e.wr, "R5 R6", "request kind", {255'b0, mreq_write}, {255'b0, e.wr});
                    chk(mreq_addr == e.addr, "R5 R6", "table address", {232'b0, mreq_addr}, {232'b0, e.addr});
                    chk(mreq_id == 4'd12, "R5", "requester id", {252'b0, mreq_id}, 12);
                    if (e.wr) begin
                        wbcount++;
                        chk(mreq_wdata == e.data, "R6", "writeback line", mreq_wdata, e.data);
                        mem[(int'(mreq_addr) - BASE) / LBYTE] = mreq_wdata;
                    end else begin
                        pend_ln = (int'(mreq_addr) - BASE) / LBYTE;
                        pend_cnt = 4;
                    end
                end
            end
            // response side
            rsp_ready = 1'b1;
            if (rsp_valid && rsp_stall > 0) begin
                rsp_ready = 1'b0;
                rsp_stall--;
            end
            if (rsp_valid) begin
                if (rexp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected response", {252'b0, rsp_tags}, '0);
                end else if (rsp_ready) begin
                    rcount++;
                    r = rexp_q.pop_front();
                    t = rtag_q.pop_front();
                    chk(rsp_covered == r.cov, t, "covered flag", {255'b0, rsp_covered}, {255'b0, r.cov});
                    chk(rsp_tags == r.tags, t, "tag vector", {252'b0, rsp_tags}, {252'b0, r.tags});
                    have_last = 1'b0;
                end else begin
                    if (have_last)
                        chk(rsp_tags == last_tags && rsp_covered == last_cov, "R12",
                            "held response", {252'b0, rsp_tags}, {252'b0, last_tags});
                    last_tags = rsp_tags; last_cov = rsp_covered; have_last = 1'b1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed, a, ln, m0, r0;
        for (int i = 0; i < NL; i++) begin m_v[i] = 1'b0; m_d[i] = 1'b0; m_ln[i] = 0; end
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk(req_ready == 1'b1, "R1", "req_ready", {255'b0, req_ready}, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid", {255'b0, rsp_valid}, 0);
        chk(mreq_valid == 1'b0, "R1", "mreq_valid", {255'b0, mreq_valid}, 0);
        chk(mrsp_ready == 1'b0, "R1", "mrsp_ready", {255'b0, mrsp_ready}, 0);

        // R1 R5 R7: first read misses, fills; a foreign-ID response is ignored
        do_req(1'b0, 24'h000000, 3, '0, "R5 R7");
        drain();
        chk(mcount == 1, "R1", "fill count after reset", 256'(mcount), 1);
        // R3: hit, no memory traffic, with a held response
        m0 = mcount;
        rsp_stall = 3;
        do_req(1'b0, 24'h000080, 1, '0, "R3");
        drain();
        chk(mcount == m0, "R3", "hit traffic", 256'(mcount), 256'(m0));
        // R4: write hits
        do_req(1'b1, 24'h000020, 0, 4'b0001, "R4");
        do_req(1'b1, 24'h000040, 3, 4'b1010, "R4");
        do_req(1'b0, 24'h000000, 3, '0, "R4");
        drain();
        chk(mcount == m0, "R4", "write hit traffic", 256'(mcount), 256'(m0));
        // R6: conflicting line evicts the dirty one
        do_req(1'b0, 24'h010000, 2, '0, "R6");
        drain();
        chk(wbcount == 1, "R6", "dirty eviction writes", 256'(wbcount), 1);
        // R6 R9: clean victim, refetch of the written-back line
        do_req(1'b0, 24'h000000, 3, '0, "R9");
        drain();
        chk(wbcount == 1, "R6", "clean eviction writes", 256'(wbcount), 1);
        // R3: frame wrap at end of line
        do_req(1'b0, 24'h001FC0, 3, '0, "R3");
        drain();
        // R2: uncovered read
        m0 = mcount;
        do_req(1'b0, 24'hF00040, 3, '0, "R2");
        do_req(1'b0, 24'hFFFFE0, 0, '0, "R2");
        drain();
        chk(mcount == m0, "R2", "uncovered traffic", 256'(mcount), 256'(m0));
        // R10: uncovered write does nothing
        m0 = mcount; r0 = rcount;
        do_req(1'b1, 24'hF00000, 3, 4'b1111, "R10");
        idle(8);
        chk(mcount == m0, "R10", "uncovered write traffic", 256'(mcount), 256'(m0));
        chk(rcount == r0 && !rsp_valid, "R10", "uncovered write response", 256'(rcount), 256'(r0));
        // R8 R9 R11: mixed traffic across conflicting lines
        seed = 32'h1234;
        for (int i = 0; i < 60; i++) begin
            seed = seed * 1103515245 + 12345;
            a = ((seed >>> 8) & 32'h3FFFF) & ~32'h1F;
            ln = (seed >>> 3) & 3;
            if (((seed >>> 20) & 3) == 0)
                do_req(1'b1, a, ln, 4'((seed >>> 12) & 4'hF), "R4");
            else if (((seed >>> 20) & 15) == 5)
                do_req(1'b0, BASE + a, ln, '0, "R2");
            else
                do_req(1'b0, a, ln, '0, "R8 R9");
        end
        drain();
        chk(rexp_q.size() == 0 && mexp_q.size() == 0, "R8", "outstanding expectations",
            256'(rexp_q.size() + mexp_q.size()), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule